// File: doc/BRIEF.md
# One-Time Clock Mode Configuration Register

This block holds the byte that selects how the chip's clock pins and oscillators behave. Software writes the byte once, right after reset, before it starts any oscillator. The block keeps the first byte-wide write it receives, and that write locks it until the next reset. Writes that cover only part of the byte are refused, and they do not use up the single write.

The stored byte drives four groups of outputs. Two of them are pin-mode selections, one for the main clock pin pair and one for the subsystem clock pin pair. The other two are a drive level for the subsystem oscillator and a frequency-range select for the main oscillator. The block also keeps two sticky flags, cleared only by reset. The illegal-setting flag is raised when the locking write carried the prohibited drive code. The ordering flag is raised when an oscillator start request arrives before the configuration is in place.

Top module: `clkmode_lock_reg`

## Requirements
- R1: After reset, the read data is 8'h00, `write_used` is 0 and both flags are 0. Both pin modes read 0 (port), the drive reads 0 (low-power) and the range bit reads 0.
- R2: A write counts only when `bus_sel` and `bus_wr` are both 1 and all 8 bits of `bus_mask` are 1. The first such write is stored from the next clock edge and sets `write_used`. Bit 3 always reads as 0.
- R3: Once `write_used` is 1, every later write leaves the read data unchanged until reset, including a write of 8'h00.
- R4: A write whose mask is not all ones changes nothing and leaves `write_used` at 0. A later full write is still accepted.
- R5: The main pin mode is decoded from stored bits [7:6]. 01 gives 1 (resonator), 11 gives 2 (external clock), and 00 or 10 give 0 (port).
- R6: The subsystem pin mode is decoded from stored bits [5:4] with the same code values as R5.
- R7: Stored bits [2:1] set the subsystem drive. 00 gives 0 (low-power), 01 gives 1 (normal) and 10 gives 2 (ultra-low). The code 11 is prohibited: the write still stores and locks, the drive output falls back to 0, and `illegal_flag` is set and stays set until reset.
- R8: `main_hi_range` equals stored bit 0. A value of 1 selects the main oscillator range above 10 MHz and up to 20 MHz.
- R9: If `osc_start` is 1 in a cycle where `write_used` is 0, `order_flag` is set from the next edge and stays set until reset. If `osc_start` is 1 only after the lock, the flag stays clear.
- R10: A write with all mask bits set has no effect when `bus_sel` or `bus_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register is addressed |
| bus_wr | input | 1 | Write strobe |
| bus_mask | input | 8 | Bit-granular write mask; all ones means a full byte access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Stored configuration byte |
| osc_start | input | 1 | Oscillator start request, observed only |
| main_pin_mode | output | 2 | Main pin pair mode: 0 port, 1 resonator, 2 external clock |
| sub_pin_mode | output | 2 | Subsystem pin pair mode, same code values |
| sub_drive | output | 2 | Subsystem oscillator drive: 0 low-power, 1 normal, 2 ultra-low |
| main_hi_range | output | 1 | Main oscillator range select |
| write_used | output | 1 | The one-time write has been consumed |
| illegal_flag | output | 1 | Sticky: prohibited drive code was written |
| order_flag | output | 1 | Sticky: oscillator start came before configuration |

## Verification
The assertions check the following on every cycle:
- the byte reads zero while unlocked;
- once locked, the byte and `write_used` never change;
- a partial-mask write never consumes the lock;
- bit 3 always reads zero;
- the drive output never shows the prohibited code;
- both flags are sticky;
- an early start request always raises the ordering flag.

The bench's scenarios cover what a single-cycle property cannot show. These are the exact decode of each pin-pair and drive code, the refusal of a write of 00H after the lock, the refusal of writes without select, and the fact that a refused partial write still leaves the following full write free to land.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      PIN_PORT      = 2'd0,
      PIN_RESONATOR = 2'd1,
      PIN_EXTCLK    = 2'd2
   } pin_mode_e;

   typedef enum logic [1:0] {
      DRV_LOW    = 2'd0,
      DRV_NORMAL = 2'd1,
      DRV_ULTRA  = 2'd2
   } drive_e;

   localparam logic [1:0] DRV_CODE_BAD = 2'b11;
endpackage

// File: rtl/clkmode_wlock.sv
// Storage with a single-use write gate; the reserved bit is never stored.
module clkmode_wlock #(
   parameter int REG_W   = 8,
   parameter int RSV_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q,
   output logic             used,
   output logic             accept
);
   localparam logic [REG_W-1:0] RSV_MASK = ~(REG_W'(1) << RSV_BIT);

   assign accept = take & ~used;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         used <= 1'b0;
      end else if (accept) begin
         q    <= wdata & RSV_MASK;
         used <= 1'b1;
      end
   end
endmodule

// File: rtl/clkmode_pin_dec.sv
// Two-bit pin-pair decode: only 01 and 11 leave port mode.
module clkmode_pin_dec
   import clkmode_pkg::*;
(
   input  logic [1:0] pair,
   output logic [1:0] mode
);
   always_comb begin
      unique case (pair)
         2'b01:   mode = PIN_RESONATOR;
         2'b11:   mode = PIN_EXTCLK;
         default: mode = PIN_PORT;
      endcase
   end
endmodule

// File: rtl/clkmode_flags.sv
// Sticky illegal-setting and ordering-violation flags.
module clkmode_flags
   import clkmode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [1:0] drv_code,
   input  logic       osc_start,
   input  logic       used,
   output logic       illegal,
   output logic       order_bad
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         illegal   <= 1'b0;
         order_bad <= 1'b0;
      end else begin
         if (accept && drv_code == DRV_CODE_BAD) illegal   <= 1'b1;
         if (osc_start && !used)                 order_bad <= 1'b1;
      end
   end
endmodule

// File: rtl/clkmode_lock_reg.sv
module clkmode_lock_reg
   import clkmode_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter int MAIN_PAIR_LSB = 6,
   parameter int SUB_PAIR_LSB  = 4,
   parameter int RSV_BIT       = 3,
   parameter int DRV_LSB       = 1,
   parameter int RANGE_BIT     = 0,
   parameter bit HAS_SUB_OSC   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [REG_W-1:0] bus_mask,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic             osc_start,
   output logic [1:0]       main_pin_mode,
   output logic [1:0]       sub_pin_mode,
   output logic [1:0]       sub_drive,
   output logic             main_hi_range,
   output logic             write_used,
   output logic             illegal_flag,
   output logic             order_flag
);
   localparam int NUM_PAIRS = 2;
   localparam int PAIR_LSB [NUM_PAIRS] = '{MAIN_PAIR_LSB, SUB_PAIR_LSB};

   if (REG_W != 8) begin : g_bad_width
      $error("clkmode_lock_reg: REG_W must be 8");
   end
   if (MAIN_PAIR_LSB + 1 >= REG_W || SUB_PAIR_LSB + 1 >= REG_W ||
       DRV_LSB + 1 >= REG_W || RANGE_BIT >= REG_W || RSV_BIT >= REG_W) begin : g_bad_field
      $error("clkmode_lock_reg: field position outside register");
   end

   logic             take;
   logic             accept;
   logic [REG_W-1:0] q;
   logic [1:0]       drv_code;
   logic [1:0]       pin_modes [NUM_PAIRS];

   assign take = bus_sel & bus_wr & (&bus_mask);

   clkmode_wlock #(.REG_W(REG_W), .RSV_BIT(RSV_BIT)) u_wlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .wdata  (bus_wdata),
      .q      (q),
      .used   (write_used),
      .accept (accept)
   );

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pin
      clkmode_pin_dec u_dec (
         .pair (q[PAIR_LSB[g] +: 2]),
         .mode (pin_modes[g])
      );
   end

   assign drv_code = bus_wdata[DRV_LSB +: 2];

   clkmode_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .drv_code  (drv_code),
      .osc_start (osc_start),
      .used      (write_used),
      .illegal   (illegal_flag),
      .order_bad (order_flag)
   );

   assign bus_rdata     = q;
   assign main_pin_mode = pin_modes[0];
   assign main_hi_range = q[RANGE_BIT];

   if (HAS_SUB_OSC) begin : g_sub
      assign sub_pin_mode = pin_modes[1];
      always_comb begin
         unique case (q[DRV_LSB +: 2])
            2'b01:   sub_drive = DRV_NORMAL;
            2'b10:   sub_drive = DRV_ULTRA;
            default: sub_drive = DRV_LOW;
         endcase
      end
   end else begin : g_no_sub
      assign sub_pin_mode = PIN_PORT;
      assign sub_drive    = DRV_LOW;
   end
endmodule

// File: rtl/clkmode_lock_reg_chk.sv
module clkmode_lock_reg_chk #(
   parameter int REG_W   = 8,
   parameter int RSV_BIT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [REG_W-1:0] bus_mask,
   input logic             osc_start,
   input logic [REG_W-1:0] bus_rdata,
   input logic [1:0]       sub_drive,
   input logic             write_used,
   input logic             illegal_flag,
   input logic             order_flag
);
   // R1: nothing is stored until the one write lands
   p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !write_used |-> bus_rdata == '0);
   // R2: the lock never clears without reset
   p_used_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      write_used |=> write_used);
   // R2: the reserved bit always reads as zero
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[RSV_BIT] == 1'b0);
   // R3: after the lock the byte holds
   p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      write_used |=> $stable(bus_rdata));
   // R4: a partial-mask write does not consume the lock
   p_partial_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !(&bus_mask) && !write_used) |=> !write_used);
   // R7: the prohibited drive code never reaches the output
   p_drive_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sub_drive != 2'b11);
   // R7: the illegal-setting flag is sticky
   p_illegal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_flag |=> illegal_flag);
   // R9: an early start request is recorded
   p_order_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_start && !write_used) |=> order_flag);
   // R9: the ordering flag is sticky
   p_order_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      order_flag |=> order_flag);
endmodule

bind clkmode_lock_reg clkmode_lock_reg_chk #(.REG_W(REG_W), .RSV_BIT(RSV_BIT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_mask     (bus_mask),
   .osc_start    (osc_start),
   .bus_rdata    (bus_rdata),
   .sub_drive    (sub_drive),
   .write_used   (write_used),
   .illegal_flag (illegal_flag),
   .order_flag   (order_flag)
);

// File: tb/test_clkmode_lock_reg.sv
module test_clkmode_lock_reg;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, osc_start = 1'b0;
   logic [7:0] bus_mask = 8'h00, bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [1:0] main_pin_mode, sub_pin_mode, sub_drive;
   logic       main_hi_range, write_used, illegal_flag, order_flag;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // behavioural reference state
   int m_val, m_used, m_ill, m_ord;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkmode_lock_reg i_clkmode_lock_reg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_mask(bus_mask), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .osc_start(osc_start), .main_pin_mode(main_pin_mode),
      .sub_pin_mode(sub_pin_mode), .sub_drive(sub_drive),
      .main_hi_range(main_hi_range), .write_used(write_used),
      .illegal_flag(illegal_flag), .order_flag(order_flag)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int pin_of(input int code);
      if (code == 1) return 1;
      if (code == 3) return 2;
      return 0;
   endfunction

   function automatic int drv_of(input int code);
      if (code == 1) return 1;
      if (code == 2) return 2;
      return 0;
   endfunction

   task automatic compare_all();
      check("R2 R3 rdata",        int'(bus_rdata),     m_val);
      check("R2 write_used",      int'(write_used),    m_used);
      check("R5 main_pin_mode",   int'(main_pin_mode), pin_of((m_val >> 6) & 3));
      check("R6 sub_pin_mode",    int'(sub_pin_mode),  pin_of((m_val >> 4) & 3));
      check("R7 sub_drive",       int'(sub_drive),     drv_of((m_val >> 1) & 3));
      check("R8 main_hi_range",   int'(main_hi_range), m_val & 1);
      check("R7 illegal_flag",    int'(illegal_flag),  m_ill);
      check("R9 order_flag",      int'(order_flag),    m_ord);
   endtask

   task automatic cyc(input bit sel, input bit wr, input logic [7:0] mask,
                      input logic [7:0] data, input bit osc);
      int was_used;
      bus_sel = sel; bus_wr = wr; bus_mask = mask; bus_wdata = data; osc_start = osc;
      @(posedge clk);
      was_used = m_used;
      if (sel && wr && mask == 8'hFF && m_used == 0) begin
         m_val  = int'(data) & 'hF7;
         m_used = 1;
         if (((int'(data) >> 1) & 3) == 3) m_ill = 1;
      end
      if (osc && was_used == 0) m_ord = 1;
      #1;
      compare_all();
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_mask = 8'h00; osc_start = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_val = 0; m_used = 0; m_ill = 0; m_ord = 0;
      #1;
      compare_all();  // R1: asynchronous clear
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();  // R1: state right after release
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected<=5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      do_reset();
      // R1: idle cycles keep reset values
      cyc(0, 0, 8'h00, 8'h00, 0);
      // R10: full write without select or without write strobe
      cyc(0, 1, 8'hFF, 8'h41, 0);
      cyc(1, 0, 8'hFF, 8'h41, 0);
      // R4: partial masks refused, lock not consumed
      cyc(1, 1, 8'h7F, 8'h41, 0);
      cyc(1, 1, 8'h01, 8'h41, 0);
      // R9: start request before configuration
      cyc(0, 0, 8'h00, 8'h00, 1);
      // R2: first full write lands; bit 3 dropped (R5 resonator, R8 range)
      cyc(1, 1, 8'hFF, 8'h4F, 0);
      // R3: later writes ignored, including zero
      cyc(1, 1, 8'hFF, 8'hC2, 0);
      cyc(1, 1, 8'hFF, 8'h00, 0);
      cyc(1, 1, 8'h0F, 8'h00, 0);

      // R7: prohibited drive code locks, falls back, raises flag
      do_reset();
      cyc(1, 1, 8'hFF, 8'hFF, 0);
      cyc(1, 1, 8'hFF, 8'h02, 0);
      // R9: start after configuration leaves order flag clear
      cyc(0, 0, 8'h00, 8'h00, 1);

      // R1 after a write of 00H; R9 clear path
      do_reset();
      cyc(1, 1, 8'hFF, 8'h00, 0);
      cyc(0, 0, 8'h00, 8'h00, 1);
      cyc(1, 1, 8'hFF, 8'hC3, 0);

      // R5 R6 R7 R8: decode patterns, each on a fresh reset
      foreach (pat_list[i]) begin
         do_reset();
         cyc(1, 1, 8'hFF, pat_list[i], 0);
         cyc(1, 1, 8'hFF, ~pat_list[i], 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   logic [7:0] pat_list [8] = '{8'h41, 8'hC2, 8'h84, 8'h10, 8'h30, 8'h20, 8'h9D, 8'h63};
endmodule